// File: doc/BRIEF.md
# Flash page program sequencer

This block sits between a CPU-style byte bus and a small flash array and enforces the order of the steps that program one page and then verify it. Software enables program mode, reads the block-protect register, loads eight bytes of one page, raises high voltage for a timed interval, and lowers it again. Only when the voltage bit is cleared after its wait has run out does the block copy the latched page into the array.

Verification then follows. Software raises the margin bit, drops the program bit, waits again, and reads the page back. Each of these margin reads stalls the bus for a fixed number of extra cycles. Every wait interval is a cycle count that software writes into a configuration register. Any control change made out of order or too early sets a sticky error flag and aborts the sequence without touching the array. Other bus accesses may fall between the steps.

Bus map: `addr_i[MSB]`=0 selects array byte `addr_i[IW-1:0]`, where page = upper bits and byte = low `log2(PAGE_BYTES)` bits. `addr_i[MSB]`=1 selects a register by `addr_i[2:0]`:
- 0 is control. Bit 0 is program, bit 1 is high voltage and bit 2 is margin.
- 1 is block protect. It reads as 0x00.
- 2 to 5 hold the wait counts, in this order: high-voltage hold, recovery, margin setup, margin-read delay.

Top module: `flash_page_seq`

## Requirements
- R1: After reset, rdy_o=1, rvalid_o=0 and err_o=0. The control register reads 0, and every array byte reads 0xFF.
- R2: The legal control values are applied in this order: 0→0x1→0x3→0x1→0x5→0x4→0x0. The control register reads back the pattern of the current step.
- R3: In program mode, array writes issued before the block-protect register has been read are ignored and set err_o.
- R4: The first page write latches the page. A write to any other page is ignored, sets err_o and is not counted. The array keeps its old content until the commit. After eight counted writes, the page is loaded.
- R5: The high-voltage bit (0x3) may only be set once a page is loaded. Clearing it (0x1) after its wait count has expired commits the latched page. Clearing it earlier sets err_o, aborts the sequence (control reads 0) and leaves the array unchanged.
- R6: Setting margin (0x5) before the recovery count has expired sets err_o and aborts the sequence. The same holds for clearing the program bit (0x4) before the margin-setup count has expired.
- R7: An array read in margin mode after the margin-read delay has expired holds rdy_o low for exactly 8 cycles. Read data is presented with a one-cycle rvalid_o pulse on the cycle that rdy_o rises. rdata_o stays stable while rdy_o is low.
- R8: Margin mode is reachable only after a page commit: writing 0x4 or 0x5 from idle sets err_o. A margin-mode read issued before the margin-read delay has expired sets err_o, aborts the sequence, and completes as a normal read.
- R9: Reads outside a legal margin read complete in one cycle. rvalid_o and the data appear in the cycle after acceptance, and rdy_o stays high.
- R10: Array writes issued while the program bit is clear are ignored and set err_o. err_o stays set until reset.
- R11: A control write that equals the current value is a no-op. Wait-register writes and reads between the steps do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request, accepted on an edge where rdy_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | IW+1 | Register/array address |
| wdata_i | input | DW | Write data |
| rdy_o | output | 1 | Low while a margin read is stretched |
| rvalid_o | output | 1 | One-cycle pulse with read data |
| rdata_o | output | DW | Read data |
| err_o | output | 1 | Sticky sequence-error flag |

## Verification
The main sequence is run twice in full, on different pages with different data. The first run is clean. In the second, an out-of-page write is injected during loading, which separates ignored writes from counted ones.

Each timed step is also struck early: the voltage clear, the margin set, and the read before the delay has expired. This checks that every counter guards its own step and that an abort leaves the array at 0xFF.

Write attempts before the protect read and with the program bit clear show that they are rejected. Margin reads are compared against normal reads of the same bytes. This tells the 8-cycle stall apart from the single-cycle path, and also checks that a premature or unauthorised margin access is never stretched.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_LOAD, ST_LOADED, ST_HV, ST_RECOV, ST_MSET, ST_MWAIT
  } seq_state_t;

  localparam logic [2:0] CTRL_NONE     = 3'b000;
  localparam logic [2:0] CTRL_PROG     = 3'b001;
  localparam logic [2:0] CTRL_PROG_HV  = 3'b011;
  localparam logic [2:0] CTRL_PROG_MRG = 3'b101;
  localparam logic [2:0] CTRL_MRG      = 3'b100;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_PROT = 3'd1;
  localparam logic [2:0] OFS_WAIT_LO = 3'd2;
  localparam logic [2:0] OFS_WAIT_HI = 3'd5;

  localparam int WT_HV    = 0;
  localparam int WT_REC   = 1;
  localparam int WT_MSET  = 2;
  localparam int WT_MREAD = 3;
  localparam int NUM_WAITS = 4;

  function automatic logic [2:0] ctrl_of(seq_state_t s);
    case (s)
      ST_ARM, ST_LOAD, ST_LOADED, ST_RECOV: ctrl_of = CTRL_PROG;
      ST_HV:    ctrl_of = CTRL_PROG_HV;
      ST_MSET:  ctrl_of = CTRL_PROG_MRG;
      ST_MWAIT: ctrl_of = CTRL_MRG;
      default:  ctrl_of = CTRL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fps_wait_timer.sv
`timescale 1ns/1ps
module fps_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fps_page_store.sv
`timescale 1ns/1ps
module fps_page_store #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 8,
  parameter int DW         = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          buf_clear_i,
  input  logic                          buf_we_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx_i,
  input  logic [DW-1:0]                 buf_data_i,
  input  logic                          commit_i,
  input  logic [$clog2(PAGES)-1:0]      commit_page_i,
  input  logic [$clog2(PAGES*PAGE_BYTES)-1:0] rd_idx_i,
  output logic [DW-1:0]                 rd_data_o
);
  localparam int DEPTH = PAGES * PAGE_BYTES;
  localparam int BW    = $clog2(PAGE_BYTES);

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] pbuf  [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (rst || buf_clear_i) begin
      for (int b = 0; b < PAGE_BYTES; b++) pbuf[b] <= '1;
    end else if (buf_we_i) begin
      pbuf[buf_idx_i] <= buf_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (commit_i) begin
      for (int b = 0; b < PAGE_BYTES; b++) cells[{commit_page_i, BW'(b)}] <= pbuf[b];
    end
  end

  assign rd_data_o = cells[rd_idx_i];
endmodule

// File: rtl/fps_read_stretch.sv
`timescale 1ns/1ps
module fps_read_stretch #(
  parameter int EXTRA = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          norm_i,
  input  logic          slow_i,
  input  logic [DW-1:0] data_i,
  output logic          rdy_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  localparam int CW = $clog2(EXTRA + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_o    <= 1'b1;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      cnt_q    <= '0;
      hold_q   <= '0;
    end else begin
      rvalid_o <= 1'b0;
      if (!rdy_o) begin
        if (cnt_q == '0) begin
          rdy_o    <= 1'b1;
          rvalid_o <= 1'b1;
          rdata_o  <= hold_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (slow_i) begin
        rdy_o  <= 1'b0;
        cnt_q  <= CW'(EXTRA - 1);
        hold_q <= data_i;
      end else if (norm_i) begin
        rvalid_o <= 1'b1;
        rdata_o  <= data_i;
      end
    end
  end
endmodule

// File: rtl/flash_page_seq.sv
`timescale 1ns/1ps
module flash_page_seq
  import fps_pkg::*;
#(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 8,
  parameter int STRETCH    = 8,
  parameter int DW         = 8,
  parameter int WAIT_INIT  = 4,
  localparam int DEPTH     = PAGES * PAGE_BYTES,
  localparam int IW        = $clog2(DEPTH),
  localparam int AW        = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rdy_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o
);
  localparam int BW = $clog2(PAGE_BYTES);
  localparam int PW = IW - BW;

  seq_state_t    state_q, state_n;
  logic [PW-1:0] page_q, page_n;
  logic [BW-1:0] wcnt_q, wcnt_n;
  logic          err_q, err_set;
  logic [DW-1:0] wait_q [NUM_WAITS];

  logic          accept, is_reg, wr_ctrl, rd_prot, wr_arr, rd_arr, wr_wait;
  logic [2:0]    roff, cur_ctrl, new_ctrl;
  logic [IW-1:0] aidx;
  logic [PW-1:0] apage;
  logic [BW-1:0] abyte;
  logic [1:0]    wsel;

  logic          tmr_load, tmr_done, commit, buf_clear, buf_we, legal;
  logic [DW-1:0] tmr_val, arr_data, rd_mux;
  logic          slow_read, norm_read;

  assign accept   = req_i & rdy_o;
  assign is_reg   = addr_i[AW-1];
  assign roff     = addr_i[2:0];
  assign aidx     = addr_i[IW-1:0];
  assign apage    = aidx[IW-1:BW];
  assign abyte    = aidx[BW-1:0];
  assign wsel     = 2'(roff - OFS_WAIT_LO);
  assign cur_ctrl = ctrl_of(state_q);
  assign new_ctrl = wdata_i[2:0];

  assign wr_ctrl = accept & we_i & is_reg & (roff == OFS_CTRL);
  assign rd_prot = accept & ~we_i & is_reg & (roff == OFS_PROT);
  assign wr_wait = accept & we_i & is_reg & (roff >= OFS_WAIT_LO) & (roff <= OFS_WAIT_HI);
  assign wr_arr  = accept & we_i & ~is_reg;
  assign rd_arr  = accept & ~we_i & ~is_reg;

  fps_wait_timer #(.W(DW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  fps_page_store #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .DW(DW)) u_store (
    .clk           (clk),
    .rst           (rst),
    .buf_clear_i   (buf_clear),
    .buf_we_i      (buf_we),
    .buf_idx_i     (abyte),
    .buf_data_i    (wdata_i),
    .commit_i      (commit),
    .commit_page_i (page_q),
    .rd_idx_i      (aidx),
    .rd_data_o     (arr_data)
  );

  always_comb begin
    state_n   = state_q;
    page_n    = page_q;
    wcnt_n    = wcnt_q;
    err_set   = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    commit    = 1'b0;
    buf_clear = 1'b0;
    buf_we    = 1'b0;
    legal     = 1'b0;
    if (wr_ctrl) begin
      if (new_ctrl != cur_ctrl) begin
        case (state_q)
          ST_IDLE: if (new_ctrl == CTRL_PROG) begin
            legal = 1'b1; state_n = ST_ARM;
          end
          ST_LOADED: if (new_ctrl == CTRL_PROG_HV) begin
            legal = 1'b1; state_n = ST_HV; tmr_load = 1'b1; tmr_val = wait_q[WT_HV];
          end
          ST_HV: if (new_ctrl == CTRL_PROG && tmr_done) begin
            legal = 1'b1; state_n = ST_RECOV; commit = 1'b1;
            tmr_load = 1'b1; tmr_val = wait_q[WT_REC];
          end
          ST_RECOV: if (new_ctrl == CTRL_PROG_MRG && tmr_done) begin
            legal = 1'b1; state_n = ST_MSET; tmr_load = 1'b1; tmr_val = wait_q[WT_MSET];
          end
          ST_MSET: if (new_ctrl == CTRL_MRG && tmr_done) begin
            legal = 1'b1; state_n = ST_MWAIT; tmr_load = 1'b1; tmr_val = wait_q[WT_MREAD];
          end
          ST_MWAIT: if (new_ctrl == CTRL_NONE && tmr_done) begin
            legal = 1'b1; state_n = ST_IDLE;
          end
          default: ;
        endcase
        if (!legal) begin
          err_set = 1'b1;
          state_n = ST_IDLE;
        end
      end
    end else if (rd_prot) begin
      if (state_q == ST_ARM) begin
        state_n   = ST_LOAD;
        wcnt_n    = '0;
        buf_clear = 1'b1;
      end
    end else if (wr_arr) begin
      if (state_q == ST_LOAD) begin
        if (wcnt_q != '0 && apage != page_q) begin
          err_set = 1'b1;
        end else begin
          buf_we = 1'b1;
          wcnt_n = wcnt_q + 1'b1;
          if (wcnt_q == '0) page_n = apage;
          if (wcnt_q == BW'(PAGE_BYTES - 1)) state_n = ST_LOADED;
        end
      end else begin
        err_set = 1'b1;
      end
    end else if (rd_arr && state_q == ST_MWAIT && !tmr_done) begin
      err_set = 1'b1;
      state_n = ST_IDLE;
    end
  end

  assign slow_read = rd_arr & (state_q == ST_MWAIT) & tmr_done;
  assign norm_read = accept & ~we_i & ~slow_read;

  always_comb begin
    rd_mux = arr_data;
    if (is_reg) begin
      if (roff == OFS_CTRL)
        rd_mux = DW'(cur_ctrl);
      else if (roff >= OFS_WAIT_LO && roff <= OFS_WAIT_HI)
        rd_mux = wait_q[wsel];
      else
        rd_mux = '0;
    end
  end

  fps_read_stretch #(.EXTRA(STRETCH), .DW(DW)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .norm_i   (norm_read),
    .slow_i   (slow_read),
    .data_i   (rd_mux),
    .rdy_o    (rdy_o),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      wcnt_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      page_q  <= page_n;
      wcnt_q  <= wcnt_n;
      if (err_set) err_q <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_WAITS; g++) begin : g_wait
      always_ff @(posedge clk) begin
        if (rst)                              wait_q[g] <= DW'(WAIT_INIT);
        else if (wr_wait && wsel == 2'(g))    wait_q[g] <= wdata_i;
      end
    end
  endgenerate

  assign err_o = err_q;
endmodule

// File: rtl/fps_checker.sv
`timescale 1ns/1ps
module fps_checker
  import fps_pkg::*;
#(
  parameter int EXTRA = 8,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy_o,
  input logic          rvalid_o,
  input logic [DW-1:0] rdata_o,
  input logic          err_o,
  input seq_state_t    state_q
);
  localparam int CW = $clog2(EXTRA + 2);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)         low_cnt <= '0;
    else if (!rdy_o) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> low_cnt == CW'(EXTRA)); // R7

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rdy_o |-> $stable(rdata_o)); // R7

  AST_RVALID_READY: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> rdy_o); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R10

  AST_HV_FROM_LOADED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HV && $past(state_q) != ST_HV) |-> $past(state_q) == ST_LOADED); // R5

  AST_MARGIN_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MSET && $past(state_q) != ST_MSET) |-> $past(state_q) == ST_RECOV); // R8
endmodule

bind flash_page_seq fps_checker #(.EXTRA(STRETCH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rdy_o    (rdy_o),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o),
  .err_o    (err_o),
  .state_q  (state_q)
);

// File: tb/flash_page_seq_test.sv
`timescale 1ns/1ps
module flash_page_seq_test;
  localparam logic [6:0] REG = 7'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rdy_o, rvalid_o, err_o;
  logic [7:0] rdata_o;

  int n_cmp = 0, n_bad = 0;

  typedef struct { logic [7:0] data; int stall; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  flash_page_seq uut (
    .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdy_o(rdy_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o)
  );

  // monitor: pops expected read results
  int stall = 0;
  always @(negedge clk) begin
    if (rst) stall = 0;
    else if (rvalid_o) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read data: actual %h expected none", rdata_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rdata_o !== e.data || stall != e.stall) begin
          n_bad++;
          $display("FAIL %s: actual data %h stall %0d expected data %h stall %0d",
                   e.tag, rdata_o, stall, e.data, e.stall);
        end
      end
      stall = 0;
    end else if (!rdy_o) stall++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input int st, input string tag);
    exp_t x;
    x.data = e; x.stall = st; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    while (!rvalid_o) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] hv, rec, ms, mr);
    wr(REG | 7'd2, hv); wr(REG | 7'd3, rec); wr(REG | 7'd4, ms); wr(REG | 7'd5, mr);
  endtask

  task automatic load_page(input int pg, input logic [7:0] seed);
    wr(REG, 8'h01);
    rd(REG | 7'd1, 8'h00, 0, "R3 protect read");
    for (int i = 0; i < 8; i++) wr(7'(pg * 8 + i), seed + 8'(i));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    // R1 reset state
    check(rdy_o === 1'b1, "R1 rdy", int'(rdy_o), 1);
    check(rvalid_o === 1'b0, "R1 rvalid", int'(rvalid_o), 0);
    check(err_o === 1'b0, "R1 err", int'(err_o), 0);
    rd(REG, 8'h00, 0, "R1 ctrl");
    rd(7'h13, 8'hFF, 0, "R1 array erased");

    // R2 / R11 / R7: full clean sequence on page 2
    cfg(8'd6, 8'd3, 8'd3, 8'd4);
    rd(REG | 7'd2, 8'd6, 0, "R11 wait reg readback");
    wr(REG, 8'h01);
    rd(REG, 8'h01, 0, "R2 ctrl prog");
    rd(REG | 7'd1, 8'h00, 0, "R3 protect read");
    for (int i = 0; i < 8; i++) begin
      wr(7'(16 + i), 8'hA0 + 8'(i));
      if (i == 3) wr(REG | 7'd3, 8'd3); // R11 unrelated access
    end
    rd(7'd16, 8'hFF, 0, "R4 array unchanged before commit");
    wr(REG, 8'h03);
    rd(REG, 8'h03, 0, "R2 ctrl hv");
    idle(10);
    wr(REG, 8'h01);
    check(err_o === 1'b0, "R5 timed hv clear", int'(err_o), 0);
    rd(7'd17, 8'hA1, 0, "R5 committed byte");
    idle(6);
    wr(REG, 8'h05);
    rd(REG, 8'h05, 0, "R2 ctrl margin setup");
    idle(6);
    wr(REG, 8'h04);
    wr(REG, 8'h04); // R11 same value no-op
    idle(8);
    for (int i = 0; i < 8; i++) rd(7'(16 + i), 8'hA0 + 8'(i), 8, "R7 margin read");
    wr(REG, 8'h00);
    check(err_o === 1'b0, "R11 clean sequence err", int'(err_o), 0);
    rd(REG, 8'h00, 0, "R2 ctrl end");
    rd(7'd18, 8'hA2, 0, "R9 normal read");

    // R4: out-of-page write during load on page 5
    wr(REG, 8'h01);
    rd(REG | 7'd1, 8'h00, 0, "R3 protect read");
    wr(7'd40, 8'h50);
    wr(7'd9, 8'h77);
    check(err_o === 1'b1, "R4 foreign page err", int'(err_o), 1);
    for (int i = 1; i < 8; i++) wr(7'(40 + i), 8'h50 + 8'(i));
    wr(REG, 8'h03); idle(10); wr(REG, 8'h01);
    rd(7'd47, 8'h57, 0, "R4 page committed after ignored write");
    rd(7'd9, 8'hFF, 0, "R4 foreign write ignored");

    // R3: write before protect read
    do_reset();
    wr(REG, 8'h01);
    wr(7'd3, 8'h12);
    check(err_o === 1'b1, "R3 write before protect", int'(err_o), 1);
    rd(REG, 8'h01, 0, "R3 still in program mode");

    // R10: write with program bit clear
    do_reset();
    wr(7'd5, 8'h33);
    check(err_o === 1'b1, "R10 write prog clear", int'(err_o), 1);
    idle(5);
    check(err_o === 1'b1, "R10 err sticky", int'(err_o), 1);
    rd(7'd5, 8'hFF, 0, "R10 write ignored");

    // R5: early hv clear
    do_reset();
    cfg(8'd40, 8'd3, 8'd3, 8'd3);
    load_page(0, 8'h20);
    wr(REG, 8'h03);
    wr(REG, 8'h01);
    check(err_o === 1'b1, "R5 early hv clear err", int'(err_o), 1);
    rd(REG, 8'h00, 0, "R5 aborted ctrl");
    rd(7'd0, 8'hFF, 0, "R5 array unchanged");

    // R6: early margin set
    do_reset();
    cfg(8'd2, 8'd40, 8'd3, 8'd3);
    load_page(1, 8'h30);
    wr(REG, 8'h03); idle(5); wr(REG, 8'h01);
    wr(REG, 8'h05);
    check(err_o === 1'b1, "R6 early margin err", int'(err_o), 1);
    rd(REG, 8'h00, 0, "R6 aborted ctrl");

    // R6: early program clear
    do_reset();
    cfg(8'd2, 8'd2, 8'd40, 8'd3);
    load_page(1, 8'h30);
    wr(REG, 8'h03); idle(5); wr(REG, 8'h01); idle(5);
    wr(REG, 8'h05);
    wr(REG, 8'h04);
    check(err_o === 1'b1, "R6 early prog clear err", int'(err_o), 1);

    // R8: margin from idle
    do_reset();
    wr(REG, 8'h04);
    check(err_o === 1'b1, "R8 margin without program", int'(err_o), 1);
    rd(7'd2, 8'hFF, 0, "R8 read not stretched");

    // R8: margin read before delay expires
    do_reset();
    cfg(8'd2, 8'd2, 8'd2, 8'd40);
    load_page(3, 8'h60);
    wr(REG, 8'h03); idle(5); wr(REG, 8'h01); idle(5);
    wr(REG, 8'h05); idle(5); wr(REG, 8'h04);
    check(err_o === 1'b0, "R8 setup clean", int'(err_o), 0);
    rd(7'd26, 8'h62, 0, "R8 early margin read normal");
    check(err_o === 1'b1, "R8 early margin read err", int'(err_o), 1);
    rd(REG, 8'h00, 0, "R8 aborted ctrl");

    idle(4);
    check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule